// File: doc/BRIEF.md
# Radix Page Tree Walker

This block translates a 64-bit effective address by walking a multi-level radix page tree held in memory. A caller presents the effective address, the base of the root table, the remaining shift that selects the root index, the root index width, the privilege of the access and its kind (load, store or instruction fetch), then pulses start. The walker issues one 8-byte read per level on a simple request/response port. Each returned entry is decoded: an entry with its valid flag clear stops the walk, a directory entry supplies the next table base and the next index width, and a leaf entry is checked for access permission and for its reference and change flags.

Each directory level takes its index width from a five-bit size field of the entry, and that width is range-checked against the shift still left, so a malformed tree ends in an error rather than in a runaway walk. When the walk ends, the block raises a one-cycle completion pulse together with a success flag, an error code and the last entry fetched. These outputs hold until the next walk ends.

Top module: `radix_walker`

## Requirements
- R1: A request carries an address whose bits 63:56 and 2:0 are zero and whose bits 55:19 are copied from the table base. Bits 18:3 take an index bit wherever the index mask has a one and a table base bit elsewhere. The index is the low 16 bits of (effective address >> (12 + shift)), and the index mask has its lowest W bits set, where W is the current mask width. The first request uses shift_i and root_msize_i. mem_req_o is high for exactly one cycle per level.
- R2: A fetched entry whose bit 63 (valid) is clear ends the walk with error code 1 (invalid).
- R3: A directory entry (bit 63 set, bit 62 clear) whose size field, bits 4:0, is below 5, above 16 or greater than the remaining shift ends the walk with error code 2 (bad tree).
- R4: A directory entry that passes the size check lowers the remaining shift by its size, makes the low 4 bits of the size the next mask width, and makes entry bits 55:8 followed by eight zero bits the next table base. The next request is then formed as in R1. A size of 16 therefore gives a mask width of 0.
- R5: For a leaf (bits 63 and 62 set), the access is eligible when priv_i is 1 or entry bit 3 (privileged-only) is clear. A load is permitted when the access is eligible and either bit 1 or bit 2 is set. A store is permitted when the access is eligible and bit 1 is set. Any other case ends the walk with error code 3 (permission).
- R6: An instruction fetch (mode_i[1] set; 00 is load, 01 is store) is permitted only when the access is eligible and entry bit 0 is set. Otherwise it fails with code 3.
- R7: A permitted leaf passes the reference/change check when bit 8 (reference) is set and either bit 7 (change) is set or the access is not a store. Failing this check gives error code 4 (RC). A leaf that fails both checks reports code 3.
- R8: A leaf that passes both checks sets ok_o to 1 with err_o equal to 0. Any completion places the last fetched entry on leaf_o.
- R9: done_o pulses for exactly one cycle, in the cycle after the final response is accepted. ok_o, err_o and leaf_o change only together with that pulse.
- R10: start_i is ignored while busy_o is high. The walk in progress finishes with the inputs it latched at its start.
- R11: After reset, busy_o, done_o, ok_o and mem_req_o are 0, err_o is 0 and leaf_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a walk (accepted only when idle) |
| ea_i | input | 64 | Effective address to translate |
| root_base_i | input | 53 | Root table base address, bits 55:3 |
| shift_i | input | 6 | Initial remaining shift |
| root_msize_i | input | 4 | Root index mask width |
| priv_i | input | 1 | 1 when the access is privileged |
| mode_i | input | 2 | Access kind: 00 load, 01 store, 1x fetch |
| mem_req_o | output | 1 | One-cycle read request |
| mem_addr_o | output | 64 | Entry address of the request |
| mem_rvalid_i | input | 1 | Read response valid |
| mem_rdata_i | input | 64 | Read response entry |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ok_o | output | 1 | Last walk succeeded |
| err_o | output | 3 | Last error code: 0 none, 1 invalid, 2 bad tree, 3 permission, 4 RC |
| leaf_o | output | 64 | Last entry fetched |

## Verification
The bench builds the walker with its default parameters: a 16-bit index field, a 12-bit page offset and size limits of 5 and 16. With a 6-bit shift this lets a random tree run up to eight directory levels before it ends at a leaf. These values also bring the edge sizes 4, 5, 16 and 17 within reach of directed cases, along with a size of 16 collapsing the next mask to zero width and a size exactly equal to the remaining shift. Random walks with random response latency, random entry types and random access kinds cover the leaf check across all three access kinds.

// File: rtl/radix_walk_pkg.sv
// Shared types for the radix tree walker.
// Assumes entries are 64 bits with the flag layout fixed by the tree format.
package radix_walk_pkg;
    typedef enum logic [2:0] {
        WERR_NONE    = 3'd0,
        WERR_INVALID = 3'd1,
        WERR_BADTREE = 3'd2,
        WERR_PERM    = 3'd3,
        WERR_RC      = 3'd4
    } walk_err_e;

    typedef enum logic [1:0] {
        WS_IDLE = 2'd0,
        WS_REQ  = 2'd1,
        WS_WAIT = 2'd2
    } walk_state_e;
endpackage

// File: rtl/radix_pte_decode.sv
// Directory-entry decoder: produces the next table base and flags a size
// field that is out of range or larger than the shift still available.
// Assumes SHIFT_W >= SIZE_W so the size can be compared without loss.
module radix_pte_decode #(
    parameter int SIZE_W   = 5,
    parameter int SHIFT_W  = 6,
    parameter int NLB_W    = 48,
    parameter int BASE_PAD = 8,
    parameter int SIZE_MIN = 5,
    parameter int SIZE_MAX = 16
) (
    input  logic [NLB_W-1:0]          nlb_field,
    input  logic [SIZE_W-1:0]         size_field,
    input  logic [SHIFT_W-1:0]        shift_left,
    output logic [NLB_W+BASE_PAD-1:0] next_base,
    output logic                      size_bad
);
    localparam logic [SIZE_W-1:0] MIN_V = SIZE_W'(SIZE_MIN);
    localparam logic [SIZE_W-1:0] MAX_V = SIZE_W'(SIZE_MAX);

    // Next base: base field placed above a zero pad.
    assign next_base = {nlb_field, {BASE_PAD{1'b0}}};

    // Range check on the size against limits and remaining shift.
    assign size_bad = (size_field < MIN_V) || (size_field > MAX_V) ||
                      (SHIFT_W'(size_field) > shift_left);
endmodule

// File: rtl/radix_leaf_check.sv
// Leaf permission and reference/change evaluation.
// Assumes mode encoding 00 load, 01 store, 1x instruction fetch.
module radix_leaf_check #(
    parameter int LOW_W = 9
) (
    input  logic [LOW_W-1:0] leaf_low,
    input  logic             priv,
    input  logic [1:0]       mode,
    output logic             perm_ok,
    output logic             rc_ok
);
    localparam int B_EXEC = 0;
    localparam int B_RW   = 1;
    localparam int B_RD   = 2;
    localparam int B_PRIV = 3;
    localparam int B_CHG  = 7;
    localparam int B_REF  = 8;

    logic is_fetch, is_store, eligible;

    // Decode the access kind.
    assign is_fetch = mode[1];
    assign is_store = !mode[1] && mode[0];
    assign eligible = priv || !leaf_low[B_PRIV];

    // Permission: fetch needs execute, data needs write or read-only for loads.
    always_comb begin
        if (is_fetch) perm_ok = eligible && leaf_low[B_EXEC];
        else          perm_ok = eligible && (leaf_low[B_RW] || (leaf_low[B_RD] && !is_store));
    end

    // Reference must be set; change must be set for stores.
    assign rc_ok = leaf_low[B_REF] && (leaf_low[B_CHG] || !is_store);

    // Bits 4..6 of the leaf are not used by the check.
    logic unused_low;
    assign unused_low = ^leaf_low[6:4];
endmodule

// File: rtl/radix_index_addr.sv
// Entry address former: merges index bits into the table base under a
// low-bits mask of width msize and drops the byte offset of an 8-byte entry.
module radix_index_addr #(
    parameter int IDX_W    = 16,
    parameter int MSZ_W    = 4,
    parameter int BASE_TOP = 56,
    parameter int ENTRY_SH = 3
) (
    input  logic [BASE_TOP-1:ENTRY_SH] tbl_base,
    input  logic [IDX_W-1:0]           idx,
    input  logic [MSZ_W-1:0]           msize,
    output logic [BASE_TOP-1:ENTRY_SH] entry_bits
);
    localparam int IDX_HI = IDX_W + ENTRY_SH - 1;

    logic [IDX_W-1:0] mask;

    // Mask with the lowest msize bits set.
    assign mask = ~({IDX_W{1'b1}} << msize);

    // Keep upper base bits; blend index field under the mask.
    always_comb begin
        entry_bits = tbl_base;
        entry_bits[IDX_HI:ENTRY_SH] = (tbl_base[IDX_HI:ENTRY_SH] & ~mask) | (idx & mask);
    end
endmodule

// File: rtl/radix_walker.sv
// Radix page tree walker. Fetches one entry per level through a
// request/response read port, descends directory entries, and reports the
// outcome of the leaf check. Assumes the memory answers every request once,
// at least one cycle after it, and that start is only honoured when idle.
module radix_walker
    import radix_walk_pkg::*;
#(
    parameter int EA_W     = 64,
    parameter int IDX_W    = 16,
    parameter int MSZ_W    = 4,
    parameter int SIZE_W   = 5,
    parameter int SHIFT_W  = 6,
    parameter int PAGE_SH  = 12,
    parameter int BASE_TOP = 56,
    parameter int ENTRY_SH = 3,
    parameter int BASE_PAD = 8,
    parameter int SIZE_MIN = 5,
    parameter int SIZE_MAX = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic [EA_W-1:0]            ea_i,
    input  logic [BASE_TOP-1:ENTRY_SH] root_base_i,
    input  logic [SHIFT_W-1:0]         shift_i,
    input  logic [MSZ_W-1:0]           root_msize_i,
    input  logic                       priv_i,
    input  logic [1:0]                 mode_i,
    output logic                       mem_req_o,
    output logic [EA_W-1:0]            mem_addr_o,
    input  logic                       mem_rvalid_i,
    input  logic [EA_W-1:0]            mem_rdata_i,
    output logic                       busy_o,
    output logic                       done_o,
    output logic                       ok_o,
    output logic [2:0]                 err_o,
    output logic [EA_W-1:0]            leaf_o
);
    localparam int VALID_BIT = EA_W - 1;
    localparam int LEAF_BIT  = EA_W - 2;
    localparam int NLB_W     = BASE_TOP - BASE_PAD;
    localparam int LOW_W     = 9;
    localparam int SH_AMT_W  = SHIFT_W + 6;

    walk_state_e                state_q;
    walk_err_e                  err_q;
    logic [EA_W-1:0]            ea_q, leaf_q;
    logic [SHIFT_W-1:0]         shift_q, shift_next;
    logic [BASE_TOP-1:ENTRY_SH] addr_q;
    logic                       priv_q, ok_q, done_q;
    logic [1:0]                 mode_q;

    logic [BASE_TOP-1:0]        dec_base;
    logic                       size_bad, perm_ok, rc_ok;
    logic [SIZE_W-1:0]          size_fld;

    logic [BASE_TOP-1:ENTRY_SH] sel_base, gen_bits;
    logic [EA_W-1:0]            sel_ea;
    logic [SHIFT_W-1:0]         sel_shift;
    logic [MSZ_W-1:0]           sel_msize;
    logic [IDX_W-1:0]           gen_idx;

    assign size_fld = mem_rdata_i[SIZE_W-1:0];

    radix_pte_decode #(
        .SIZE_W(SIZE_W), .SHIFT_W(SHIFT_W), .NLB_W(NLB_W), .BASE_PAD(BASE_PAD),
        .SIZE_MIN(SIZE_MIN), .SIZE_MAX(SIZE_MAX)
    ) u_dec (
        .nlb_field (mem_rdata_i[BASE_TOP-1:BASE_PAD]),
        .size_field(size_fld),
        .shift_left(shift_q),
        .next_base (dec_base),
        .size_bad  (size_bad)
    );

    radix_leaf_check #(.LOW_W(LOW_W)) u_leaf (
        .leaf_low(mem_rdata_i[LOW_W-1:0]),
        .priv    (priv_q),
        .mode    (mode_q),
        .perm_ok (perm_ok),
        .rc_ok   (rc_ok)
    );

    // Remaining shift after descending through the current directory entry.
    assign shift_next = shift_q - SHIFT_W'(size_fld);

    // Address-former operands: root inputs when idle, decoded entry otherwise.
    always_comb begin
        if (state_q == WS_IDLE) begin
            sel_base  = root_base_i;
            sel_ea    = ea_i;
            sel_shift = shift_i;
            sel_msize = root_msize_i;
        end else begin
            sel_base  = dec_base[BASE_TOP-1:ENTRY_SH];
            sel_ea    = ea_q;
            sel_shift = shift_next;
            sel_msize = size_fld[MSZ_W-1:0];
        end
    end

    // Index: low bits of the address past the page offset and the shift.
    assign gen_idx = IDX_W'(sel_ea >> (SH_AMT_W'(PAGE_SH) + SH_AMT_W'(sel_shift)));

    radix_index_addr #(
        .IDX_W(IDX_W), .MSZ_W(MSZ_W), .BASE_TOP(BASE_TOP), .ENTRY_SH(ENTRY_SH)
    ) u_addr (
        .tbl_base  (sel_base),
        .idx       (gen_idx),
        .msize     (sel_msize),
        .entry_bits(gen_bits)
    );

    // Walk sequencer with result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WS_IDLE;
            err_q   <= WERR_NONE;
            ok_q    <= 1'b0;
            done_q  <= 1'b0;
            leaf_q  <= '0;
            ea_q    <= '0;
            shift_q <= '0;
            addr_q  <= '0;
            priv_q  <= 1'b0;
            mode_q  <= 2'b00;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                WS_IDLE: begin
                    if (start_i) begin
                        ea_q    <= ea_i;
                        shift_q <= shift_i;
                        priv_q  <= priv_i;
                        mode_q  <= mode_i;
                        addr_q  <= gen_bits;
                        state_q <= WS_REQ;
                    end
                end
                WS_REQ: state_q <= WS_WAIT;
                WS_WAIT: begin
                    if (mem_rvalid_i) begin
                        if (!mem_rdata_i[VALID_BIT] || mem_rdata_i[LEAF_BIT] || size_bad) begin
                            state_q <= WS_IDLE;
                            done_q  <= 1'b1;
                            leaf_q  <= mem_rdata_i;
                            ok_q    <= 1'b0;
                            if (!mem_rdata_i[VALID_BIT])     err_q <= WERR_INVALID;
                            else if (!mem_rdata_i[LEAF_BIT]) err_q <= WERR_BADTREE;
                            else if (!perm_ok)               err_q <= WERR_PERM;
                            else if (!rc_ok)                 err_q <= WERR_RC;
                            else begin
                                err_q <= WERR_NONE;
                                ok_q  <= 1'b1;
                            end
                        end else begin
                            shift_q <= shift_next;
                            addr_q  <= gen_bits;
                            state_q <= WS_REQ;
                        end
                    end
                end
                default: state_q <= WS_IDLE;
            endcase
        end
    end

    // Port view of the registered state.
    assign mem_req_o  = (state_q == WS_REQ);
    assign mem_addr_o = {{(EA_W-BASE_TOP){1'b0}}, addr_q, {ENTRY_SH{1'b0}}};
    assign busy_o     = (state_q != WS_IDLE);
    assign done_o     = done_q;
    assign ok_o       = ok_q;
    assign err_o      = err_q;
    assign leaf_o     = leaf_q;
endmodule

// File: rtl/radix_walker_chk.sv
// Temporal checks on the walker ports, attached to every radix_walker.
module radix_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic        busy_o,
    input logic        done_o,
    input logic        ok_o,
    input logic [2:0]  err_o,
    input logic [63:0] leaf_o,
    input logic        mem_req_o,
    input logic [63:0] mem_addr_o,
    input logic        mem_rvalid_i
);
    // R1: entry addresses are aligned and confined below bit 56.
    p_req_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (mem_addr_o[2:0] == 3'd0 && mem_addr_o[63:56] == 8'd0));

    // R1: a request lasts one cycle.
    p_req_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |=> !mem_req_o);

    // R2: an invalid-entry result carries an entry with the valid flag clear.
    p_invalid_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o == 3'd1) |-> !leaf_o[63]);

    // R7: a successful leaf has its reference flag set.
    p_ref_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ok_o |-> leaf_o[8]);

    // R8: success implies no error and a valid leaf.
    p_ok_leaf_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ok_o |-> (err_o == 3'd0 && leaf_o[63] && leaf_o[62]));

    // R9: completion pulse is one cycle long.
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9: results hold outside the completion pulse.
    p_hold_results_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(err_o) && $stable(ok_o) && $stable(leaf_o)));

    // R9: completion follows an accepted response.
    p_done_after_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(mem_rvalid_i));

    // R10: a start while busy and waiting does not end the walk.
    p_ignore_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !mem_rvalid_i) |=> busy_o);

    // R11: no request while idle.
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mem_req_o);
endmodule

bind radix_walker radix_walker_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .ok_o        (ok_o),
    .err_o       (err_o),
    .leaf_o      (leaf_o),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_rvalid_i(mem_rvalid_i)
);

// File: tb/radix_walker_tb.sv
`timescale 1ns/1ps
module radix_walker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [63:0] ea_i = '0;
    logic [55:3] root_base_i = '0;
    logic [5:0]  shift_i = '0;
    logic [3:0]  root_msize_i = '0;
    logic        priv_i = 1'b0;
    logic [1:0]  mode_i = 2'b00;
    logic        mem_req_o;
    logic [63:0] mem_addr_o;
    logic        mem_rvalid_i = 1'b0;
    logic [63:0] mem_rdata_i = '0;
    logic        busy_o, done_o, ok_o;
    logic [2:0]  err_o;
    logic [63:0] leaf_o;

    int n_chk = 0;
    int n_fail = 0;

    logic [63:0] script [16];
    logic [63:0] exp_addr [16];
    logic [63:0] got_addr [16];
    int          exp_n, got_n;
    logic [2:0]  exp_err;
    logic [63:0] exp_leaf;

    always #2 clk = ~clk;

    radix_walker u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ea_i(ea_i),
        .root_base_i(root_base_i), .shift_i(shift_i), .root_msize_i(root_msize_i),
        .priv_i(priv_i), .mode_i(mode_i), .mem_req_o(mem_req_o),
        .mem_addr_o(mem_addr_o), .mem_rvalid_i(mem_rvalid_i),
        .mem_rdata_i(mem_rdata_i), .busy_o(busy_o), .done_o(done_o),
        .ok_o(ok_o), .err_o(err_o), .leaf_o(leaf_o)
    );

    task automatic check(input bit cond, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Expected entry address (R1/R4), built bit by bit.
    function automatic logic [63:0] f_addr(logic [63:0] base, logic [63:0] ea,
                                           int sh, int msz);
        logic [63:0] a;
        logic [63:0] s;
        s = ea >> (12 + sh);
        a = '0;
        for (int b = 3; b < 56; b++) a[b] = base[b];
        for (int k = 0; k < 16; k++) if (k < msz) a[k+3] = s[k];
        return a;
    endfunction

    // Expected leaf outcome (R5, R6, R7, R8).
    function automatic logic [2:0] f_leaf(logic [63:0] e, bit priv, logic [1:0] mode);
        bit elig, perm, rc, st;
        st   = (mode == 2'b01);
        elig = priv || !e[3];
        if (mode[1]) perm = elig && e[0];
        else         perm = elig && (e[1] || (e[2] && !st));
        rc = e[8] && (e[7] || !st);
        if (!perm) return 3'd3;
        if (!rc)   return 3'd4;
        return 3'd0;
    endfunction

    // Reference walk over the script.
    task automatic model(input logic [63:0] ea, input logic [63:0] base0, input int sh0,
                         input int msz0, input bit priv, input logic [1:0] mode);
        int sh, msz, sz;
        logic [63:0] base, e;
        sh = sh0; msz = msz0; base = base0;
        exp_n = 0; exp_err = 3'd0; exp_leaf = '0;
        for (int l = 0; l < 16; l++) begin
            exp_addr[l] = f_addr(base, ea, sh, msz);
            exp_n = l + 1;
            e = script[l];
            exp_leaf = e;
            if (!e[63]) begin exp_err = 3'd1; break; end
            if (e[62]) begin exp_err = f_leaf(e, priv, mode); break; end
            sz = int'(e[4:0]);
            if (sz < 5 || sz > 16 || sz > sh) begin exp_err = 3'd2; break; end
            sh  = sh - sz;
            msz = sz % 16;
            base = {8'h00, e[55:8], 8'h00};
        end
    endtask

    function automatic logic [63:0] mk_leaf(logic [8:0] low);
        return {2'b11, 53'h0, low};
    endfunction

    function automatic logic [63:0] mk_dir(logic [47:0] nb, logic [4:0] sz);
        return {2'b10, 6'h0, nb, 3'h0, sz};
    endfunction

    // Drive one walk, answer the requests, compare against the model.
    task automatic run_walk(input logic [63:0] ea, input logic [63:0] base, input int sh,
                            input int msz, input bit priv, input logic [1:0] mode,
                            input bit poke, input string tag);
        bit fin;
        int lat;
        logic [2:0]  e_hold;
        logic [63:0] l_hold;
        model(ea, base, sh, msz, priv, mode);
        @(negedge clk);
        ea_i = ea; root_base_i = base[55:3]; shift_i = 6'(sh);
        root_msize_i = 4'(msz); priv_i = priv; mode_i = mode; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        fin = 0; got_n = 0;
        while (!fin && got_n < 16) begin
            if (done_o) fin = 1;
            else if (mem_req_o) begin
                got_addr[got_n] = mem_addr_o;
                lat = 1 + int'($urandom % 3);
                for (int w = 0; w < lat; w++) begin
                    if (poke && w == 0) begin
                        // R10: start with other inputs while busy
                        start_i = 1'b1; ea_i = ~ea; shift_i = ~shift_i; mode_i = ~mode;
                    end
                    @(negedge clk);
                    start_i = 1'b0;
                end
                mem_rvalid_i = 1'b1;
                mem_rdata_i  = script[got_n];
                got_n++;
                @(negedge clk);
                mem_rvalid_i = 1'b0;
            end else @(negedge clk);
        end
        check(got_n == exp_n, {tag, " R4 level count"}, 64'(got_n), 64'(exp_n));
        for (int l = 0; l < 16; l++)
            if (l < got_n && l < exp_n)
                check(got_addr[l] == exp_addr[l], l == 0 ? {tag, " R1 root addr"} : {tag, " R4 next addr"},
                      got_addr[l], exp_addr[l]);
        check(done_o == 1'b1, {tag, " R9 done pulse"}, 64'(done_o), 64'd1);
        check(err_o == exp_err, {tag, " R2/R3/R5/R6/R7 err code"}, 64'(err_o), 64'(exp_err));
        check(ok_o == (exp_err == 3'd0), {tag, " R8 ok flag"}, 64'(ok_o), 64'(exp_err == 3'd0));
        check(leaf_o == exp_leaf, {tag, " R8 leaf entry"}, leaf_o, exp_leaf);
        e_hold = err_o; l_hold = leaf_o;
        @(negedge clk);
        check(done_o == 1'b0, {tag, " R9 pulse length"}, 64'(done_o), 64'd0);
        check(err_o == e_hold && leaf_o == l_hold, {tag, " R9 hold"}, leaf_o, l_hold);
    endtask

    // Watchdog: a hung run is a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] e;
        int r, sz;
        void'($urandom(32'h5eed_7a1c));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        check(!busy_o && !done_o && !ok_o && !mem_req_o, "R11 reset flags",
              {60'h0, busy_o, done_o, ok_o, mem_req_o}, 64'h0);
        check(err_o == 3'd0 && leaf_o == 64'h0, "R11 reset results", leaf_o, 64'h0);

        // R2: invalid root entry
        script[0] = 64'h7fff_ffff_ffff_ffff;
        run_walk(64'h1234_5678_9abc_def0, 64'h0000_0000_0012_3400, 20, 9, 1, 2'b00, 0, "R2 invalid");
        // R3: size below minimum, above maximum, above remaining shift
        script[0] = mk_dir(48'h000400, 5'd4);
        run_walk(64'hdead_beef_0000_1000, 64'h0000_0000_0003_0000, 30, 9, 1, 2'b00, 0, "R3 size4");
        script[0] = mk_dir(48'h000400, 5'd17);
        run_walk(64'hdead_beef_0000_1000, 64'h0000_0000_0003_0000, 30, 9, 1, 2'b00, 0, "R3 size17");
        script[0] = mk_dir(48'h000400, 5'd7);
        run_walk(64'hfeed_0000_1234_5000, 64'h0000_0000_0003_0000, 6, 9, 1, 2'b00, 0, "R3 over shift");
        // R4: size equal to shift, then size 16 giving a zero-width mask
        script[0] = mk_dir(48'h000400, 5'd7);
        script[1] = mk_leaf(9'h187);
        run_walk(64'hfeed_0000_1234_5000, 64'h0000_0000_0003_0000, 7, 9, 1, 2'b00, 0, "R4 exact shift");
        script[0] = mk_dir(48'h00abcd, 5'd16);
        script[1] = mk_leaf(9'h187);
        run_walk(64'hffff_ffff_ffff_ffff, 64'h0000_0000_0003_0000, 20, 5, 1, 2'b00, 0, "R4 size16");
        // R5: privileged-only page from unprivileged access
        script[0] = mk_leaf(9'h18e);
        run_walk(64'h0, 64'h0000_0000_0004_0000, 10, 4, 0, 2'b00, 0, "R5 priv only");
        // R5: store to read-only page; load from same page
        script[0] = mk_leaf(9'h184);
        run_walk(64'h0, 64'h0000_0000_0004_0000, 10, 4, 1, 2'b01, 0, "R5 store ro");
        run_walk(64'h0, 64'h0000_0000_0004_0000, 10, 4, 1, 2'b00, 0, "R5 load ro");
        // R6: fetch with and without execute
        script[0] = mk_leaf(9'h181);
        run_walk(64'h0, 64'h0000_0000_0004_0000, 10, 4, 1, 2'b10, 0, "R6 exec");
        script[0] = mk_leaf(9'h186);
        run_walk(64'h0, 64'h0000_0000_0004_0000, 10, 4, 1, 2'b11, 0, "R6 no exec");
        // R7: store without change bit; both checks failing
        script[0] = mk_leaf(9'h102);
        run_walk(64'h0, 64'h0000_0000_0004_0000, 10, 4, 1, 2'b01, 0, "R7 no change");
        script[0] = mk_leaf(9'h004);
        run_walk(64'h0, 64'h0000_0000_0004_0000, 10, 4, 1, 2'b01, 0, "R7 perm first");
        // R10: start pulsed during a two-level walk
        script[0] = mk_dir(48'h000777, 5'd9);
        script[1] = mk_leaf(9'h187);
        run_walk(64'h0123_4567_89ab_cdef, 64'h0000_0000_0005_0000, 30, 12, 1, 2'b00, 1, "R10 poke");

        // Random trees
        for (int t = 0; t < 300; t++) begin
            for (int l = 0; l < 16; l++) begin
                r = int'($urandom % 10);
                e = {$urandom, $urandom};
                if (r == 0) e[63] = 1'b0;
                else if (r < 4) begin e[63] = 1'b1; e[62] = 1'b1; end
                else begin
                    e[63] = 1'b1; e[62] = 1'b0;
                    sz = (r == 9) ? int'($urandom % 32) : 5 + int'($urandom % 6);
                    e[4:0] = 5'(sz);
                end
                script[l] = e;
            end
            run_walk({$urandom, $urandom}, {$urandom, $urandom}, 8 + int'($urandom % 33),
                     int'($urandom % 16), 1'($urandom), 2'($urandom), t % 7 == 0, "random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule